// File: doc/BRIEF.md
# Multi-Port GPIO Bank with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller holding a parameterised number of ports, each with eight pins. A simple synchronous register bus reaches a shared control/identification word and, per port, a window of configuration and status registers. Each pin has its own drive style (input, push-pull, open-drain or open-source), output value and pull-up enable. At the pad boundary every pin presents an output value, an output enable and a pull enable, and receives an input value.

Pin inputs are resynchronised (two flops, or one when the fast path is chosen) and watched for one selectable edge per pin. A detected edge, or a bit held in the port's force register, sets a sticky event bit that software clears by writing a one. Each port has its own interrupt line, raised while any enabled event of that port is set and the block is switched on. The register bus is a control path, not a data stream: a request is taken on every cycle that `bus_sel` is high, with no back-pressure, and read data appears on the cycle after the read request.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register holds zero: all pad output enables are low, all pull enables are high, all pad outputs are low and every interrupt line is low.
- R2: Port p owns byte addresses p*0x30 to p*0x30+0x2F. Inside a window the offsets are 0x04 synchronised pin state, 0x08 output data, 0x0C drive modes, 0x10 pull disable, 0x14 events, 0x18 interrupt enable, 0x1C force, 0x20 edge select; pin k sits at bit k. Any other offset, and any address past the last window, reads zero and ignores writes. Read data is registered and is valid on the cycle after the read request; it holds its value otherwise.
- R3: The drive-mode register has two bits per pin, pin k at bits [2k+1:2k]: 00 input (enable off), 01 push-pull (enable on), 10 open-drain (enable on only while the output bit is 0), 11 open-source (enable on only while the output bit is 1). The pad output value always equals the output data bit.
- R4: A 1 in a pin's pull-disable bit turns its pull enable output low; a 0 keeps the pull-up on.
- R5: Offset 0x04 returns the resynchronised pin state: through two flops when control bit 1 is 1, through one flop when it is 0.
- R6: Edge select bit 0 makes the pin set its event on a falling edge of the resynchronised input, 1 on a rising edge; the other edge sets nothing.
- R7: Writing a 1 to an event bit clears it; a bit set by an edge or by the force register in the same cycle stays set.
- R8: A port's interrupt line is high exactly when the block is on and at least one of its pins has both its event bit and its enable bit set.
- R9: While a force bit is 1 the matching event bit is set on every cycle; after the force bit is written back to 0 the event can be cleared.
- R10: While control bit 0 is 0 the block is off: no edge and no force bit sets an event, all interrupt lines are low, and all registers remain readable and writable.
- R11: Offset 0x00 of every window reaches the one shared control register: bits [15:9] read the port count, bits [8:2] the version, bits [1:0] are writable and everything else reads zero.
- R12: Writes to the pin-state offset and to the read-only control fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pad_in | input | NUM_PORTS*8 | Pad input values, port p pin k at bit 8p+k |
| pad_out | output | NUM_PORTS*8 | Pad output values |
| pad_oe | output | NUM_PORTS*8 | Pad output enables |
| pad_pull_en | output | NUM_PORTS*8 | Pad pull-up enables |
| irq | output | NUM_PORTS | One interrupt line per port |

## Verification
The assertions take for granted that `bus_sel`, `bus_wr` and, during a request, the address and write data are known values after reset; pad inputs may change on any cycle because they pass the resynchroniser first. The stimulus drives every input on the falling clock edge, so all of them are settled at the rising edge. Directed sequences cover each mode and the clear-versus-set collision, and a long phase of random pad values and random bus traffic over the whole address range, unaligned offsets included, is compared each cycle with a behavioural model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PINS      = 8;
  localparam int WIN_BYTES = 48;
  localparam int WORD_W    = 32;

  typedef enum logic [1:0] {
    DRV_IN = 2'b00,
    DRV_PP = 2'b01,
    DRV_OD = 2'b10,
    DRV_OS = 2'b11
  } drive_e;

  localparam logic [5:0] OFF_CTRL = 6'h00;
  localparam logic [5:0] OFF_PIN  = 6'h04;
  localparam logic [5:0] OFF_DOUT = 6'h08;
  localparam logic [5:0] OFF_DRV  = 6'h0C;
  localparam logic [5:0] OFF_PULL = 6'h10;
  localparam logic [5:0] OFF_EVT  = 6'h14;
  localparam logic [5:0] OFF_IEN  = 6'h18;
  localparam logic [5:0] OFF_FRC  = 6'h1C;
  localparam logic [5:0] OFF_EDGE = 6'h20;
endpackage

// File: rtl/gpio_bank_insync.sv
module gpio_bank_insync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         two_stage,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d;
      stg2_q <= stg1_q;
    end
  end

  assign q = two_stage ? stg2_q : stg1_q;
endmodule

// File: rtl/gpio_bank_paddrv.sv
module gpio_bank_paddrv
  import gpio_bank_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       dout,
  output logic       oe
);
  always_comb begin
    case (drive_e'(mode))
      DRV_PP:  oe = 1'b1;
      DRV_OD:  oe = ~dout;
      DRV_OS:  oe = dout;
      default: oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_en,
  input  logic              wr_en,
  input  logic [5:0]        off,
  input  logic [15:0]       wdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [WORD_W-1:0] rd_word,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_pull_en,
  output logic              irq
);
  logic [PINS-1:0]   dout_q, pull_off_q, ien_q, frc_q, rise_sel_q, ev_q, prev_q;
  logic [2*PINS-1:0] drv_q;
  logic [PINS-1:0]   rise_seen, fall_seen, edge_hit, ev_set, ev_clr;

  assign rise_seen = pin_in & ~prev_q;
  assign fall_seen = ~pin_in & prev_q;
  assign edge_hit  = (rise_sel_q & rise_seen) | (~rise_sel_q & fall_seen);
  assign ev_set    = blk_en ? (edge_hit | frc_q) : '0;
  assign ev_clr    = (wr_en && off == OFF_EVT) ? wdata[PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q     <= '0;
      drv_q      <= '0;
      pull_off_q <= '0;
      ien_q      <= '0;
      frc_q      <= '0;
      rise_sel_q <= '0;
      ev_q       <= '0;
      prev_q     <= '0;
    end else begin
      prev_q <= pin_in;
      ev_q   <= (ev_q & ~ev_clr) | ev_set;
      if (wr_en) begin
        case (off)
          OFF_DOUT: dout_q     <= wdata[PINS-1:0];
          OFF_DRV:  drv_q      <= wdata;
          OFF_PULL: pull_off_q <= wdata[PINS-1:0];
          OFF_IEN:  ien_q      <= wdata[PINS-1:0];
          OFF_FRC:  frc_q      <= wdata[PINS-1:0];
          OFF_EDGE: rise_sel_q <= wdata[PINS-1:0];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (off)
      OFF_PIN:  rd_word = WORD_W'(pin_in);
      OFF_DOUT: rd_word = WORD_W'(dout_q);
      OFF_DRV:  rd_word = WORD_W'(drv_q);
      OFF_PULL: rd_word = WORD_W'(pull_off_q);
      OFF_EVT:  rd_word = WORD_W'(ev_q);
      OFF_IEN:  rd_word = WORD_W'(ien_q);
      OFF_FRC:  rd_word = WORD_W'(frc_q);
      OFF_EDGE: rd_word = WORD_W'(rise_sel_q);
      default:  rd_word = '0;
    endcase
  end

  for (genvar k = 0; k < PINS; k++) begin : g_pin
    gpio_bank_paddrv u_drv (
      .mode (drv_q[2*k+1:2*k]),
      .dout (dout_q[k]),
      .oe   (pad_oe[k])
    );
  end

  assign pad_out     = dout_q;
  assign pad_pull_en = ~pull_off_q;
  assign irq         = blk_en & (|(ev_q & ien_q));

  // R9
  force_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_en && frc_q != '0) |=> ((ev_q & $past(frc_q)) == $past(frc_q)));

  // R10
  off_no_new_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_en |=> ((ev_q & ~$past(ev_q)) == '0));

  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_en && ev_clr != '0) |=> ((ev_q & $past(ev_clr)) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int         NUM_PORTS = 7,
  parameter logic [6:0] VERSION   = 7'h05,
  parameter int         ADDR_W    = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [WORD_W-1:0]         bus_wdata,
  output logic [WORD_W-1:0]         bus_rdata,
  input  logic [NUM_PORTS*PINS-1:0] pad_in,
  output logic [NUM_PORTS*PINS-1:0] pad_out,
  output logic [NUM_PORTS*PINS-1:0] pad_oe,
  output logic [NUM_PORTS*PINS-1:0] pad_pull_en,
  output logic [NUM_PORTS-1:0]      irq
);
  localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [1:0]        ctrl_q;
  logic [PIDX_W-1:0] hit_port;
  logic [5:0]        win_off;
  logic              win_hit, ctrl_hit;
  logic [WORD_W-1:0] ctrl_word, rdata_d;
  logic [WORD_W-1:0] port_rd [NUM_PORTS];
  logic [15:0]       unused_wdata_hi;

  assign unused_wdata_hi = bus_wdata[WORD_W-1:16];

  always_comb begin
    hit_port = '0;
    win_off  = '0;
    win_hit  = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (int'(bus_addr) >= p * WIN_BYTES && int'(bus_addr) < (p + 1) * WIN_BYTES) begin
        hit_port = PIDX_W'(p);
        win_off  = 6'(int'(bus_addr) - p * WIN_BYTES);
        win_hit  = 1'b1;
      end
    end
  end

  assign ctrl_hit  = win_hit && (win_off == OFF_CTRL);
  assign ctrl_word = {16'h0, 7'(NUM_PORTS), VERSION, ctrl_q};
  assign rdata_d   = ctrl_hit ? ctrl_word : (win_hit ? port_rd[hit_port] : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_sel && bus_wr && ctrl_hit) ctrl_q <= bus_wdata[1:0];
      if (bus_sel && !bus_wr) bus_rdata <= rdata_d;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PINS-1:0] pin_sync;

    gpio_bank_insync #(.W(PINS)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .two_stage (ctrl_q[1]),
      .d         (pad_in[p*PINS +: PINS]),
      .q         (pin_sync)
    );

    gpio_bank_port u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .blk_en      (ctrl_q[0]),
      .wr_en       (bus_sel && bus_wr && win_hit && hit_port == PIDX_W'(p)),
      .off         (win_off),
      .wdata       (bus_wdata[15:0]),
      .pin_in      (pin_sync),
      .rd_word     (port_rd[p]),
      .pad_out     (pad_out[p*PINS +: PINS]),
      .pad_oe      (pad_oe[p*PINS +: PINS]),
      .pad_pull_en (pad_pull_en[p*PINS +: PINS]),
      .irq         (irq[p])
    );
  end

  // R11
  ctrl_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && ctrl_hit) |=>
      (bus_rdata[15:9] == 7'(NUM_PORTS) && bus_rdata[8:2] == VERSION && bus_rdata[31:16] == '0));

  // R10
  off_irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && ctrl_hit && !bus_wdata[0]) |=> (irq == '0));
endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 7;
  localparam int NPIN = NP * 8;
  localparam logic [6:0] VER = 7'h05;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [8:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NPIN-1:0] pad_in = '0;
  logic [NPIN-1:0] pad_out, pad_oe, pad_pull_en;
  logic [NP-1:0] irq;

  int checks = 0, fails = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank #(.NUM_PORTS(NP), .VERSION(VER), .ADDR_W(9)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull_en(pad_pull_en), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_dout [NP], m_pull [NP], m_ien [NP], m_frc [NP], m_rise [NP];
  logic [7:0]  m_ev [NP], m_h1 [NP], m_h2 [NP], m_prev [NP];
  logic [15:0] m_drv [NP];
  logic [1:0]  m_ctrl;
  logic [31:0] m_rdata;

  function automatic logic [7:0] m_pins(int p);
    return m_ctrl[1] ? m_h2[p] : m_h1[p];
  endfunction

  function automatic logic [31:0] m_read(int a);
    int p, o;
    if (a >= NP * 48) return 32'h0;
    p = a / 48;
    o = a % 48;
    case (o)
      0:  return {16'h0, 7'(NP), VER, m_ctrl};
      4:  return {24'h0, m_pins(p)};
      8:  return {24'h0, m_dout[p]};
      12: return {16'h0, m_drv[p]};
      16: return {24'h0, m_pull[p]};
      20: return {24'h0, m_ev[p]};
      24: return {24'h0, m_ien[p]};
      28: return {24'h0, m_frc[p]};
      32: return {24'h0, m_rise[p]};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_dout[p] = 0; m_pull[p] = 0; m_ien[p] = 0; m_frc[p] = 0; m_rise[p] = 0;
        m_ev[p] = 0; m_h1[p] = 0; m_h2[p] = 0; m_prev[p] = 0; m_drv[p] = 0;
      end
      m_ctrl = 0;
      m_rdata = 0;
    end else begin
      int a, wp, wo;
      logic [7:0] cur [NP];
      logic [1:0] next_ctrl;
      a = int'(bus_addr);
      wp = (a < NP * 48) ? a / 48 : -1;
      wo = a % 48;
      next_ctrl = m_ctrl;
      for (int p = 0; p < NP; p++) cur[p] = m_pins(p);
      if (bus_sel && !bus_wr) m_rdata = m_read(a);
      for (int p = 0; p < NP; p++) begin
        for (int k = 0; k < 8; k++) begin
          bit was, now, fire;
          was = m_prev[p][k];
          now = cur[p][k];
          fire = m_rise[p][k] ? (now && !was) : (!now && was);
          if (bus_sel && bus_wr && wp == p && wo == 20 && bus_wdata[k]) m_ev[p][k] = 1'b0;
          if (m_ctrl[0] && (fire || m_frc[p][k])) m_ev[p][k] = 1'b1;
        end
      end
      if (bus_sel && bus_wr && wp >= 0) begin
        case (wo)
          0:  next_ctrl = bus_wdata[1:0];
          8:  m_dout[wp] = bus_wdata[7:0];
          12: m_drv[wp] = bus_wdata[15:0];
          16: m_pull[wp] = bus_wdata[7:0];
          24: m_ien[wp] = bus_wdata[7:0];
          28: m_frc[wp] = bus_wdata[7:0];
          32: m_rise[wp] = bus_wdata[7:0];
          default: ;
        endcase
      end
      for (int p = 0; p < NP; p++) begin
        m_prev[p] = cur[p];
        m_h2[p] = m_h1[p];
        m_h1[p] = pad_in[p*8 +: 8];
      end
      m_ctrl = next_ctrl;
    end
  end

  // per-cycle comparison of every output with the model
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [NPIN-1:0] e_oe, e_out, e_pull;
      logic [NP-1:0] e_irq;
      for (int p = 0; p < NP; p++) begin
        e_irq[p] = m_ctrl[0] && ((m_ev[p] & m_ien[p]) != 0);
        for (int k = 0; k < 8; k++) begin
          logic [1:0] md;
          md = m_drv[p][2*k +: 2];
          e_out[p*8+k]  = m_dout[p][k];
          e_pull[p*8+k] = !m_pull[p][k];
          case (md)
            2'b01:   e_oe[p*8+k] = 1'b1;
            2'b10:   e_oe[p*8+k] = !m_dout[p][k];
            2'b11:   e_oe[p*8+k] = m_dout[p][k];
            default: e_oe[p*8+k] = 1'b0;
          endcase
        end
      end
      chk("R3 model pad_oe", 64'(pad_oe), 64'(e_oe));
      chk("R3 model pad_out", 64'(pad_out), 64'(e_out));
      chk("R4 model pad_pull_en", 64'(pad_pull_en), 64'(e_pull));
      chk("R8 model irq", 64'(irq), 64'(e_irq));
      chk("R2 model bus_rdata", 64'(bus_rdata), 64'(m_rdata));
    end
  end

  // ---------------- bus tasks (called at a falling edge) ----------------
  task automatic wr(input int a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 9'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 9'(a);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pad_oe", 64'(pad_oe), 64'h0);
    chk("R1 pad_pull_en", 64'(pad_pull_en), 64'({NPIN{1'b1}}));
    chk("R1 pad_out", 64'(pad_out), 64'h0);
    chk("R1 irq", 64'(irq), 64'h0);
    rd(32'h00, v); chk("R1 R11 ctrl after reset", 64'(v), 64'h0E14);

    // R11 / R12 control register fields and window aliasing
    wr(32'h00, 32'hFFFF_FFFF);
    rd(32'h30, v); chk("R11 R12 ctrl alias in port 1 window", 64'(v), 64'h0E17);

    // R3 drive modes: pin0 input, pin1 push-pull, pin2 open-drain, pin3 open-source
    wr(32'h0C, 32'h0000_00E4);
    wr(32'h08, 32'h0000_000F);
    chk("R3 oe with data high", 64'(pad_oe[3:0]), 64'b1010);
    chk("R3 pad_out follows data", 64'(pad_out[7:0]), 64'h0F);
    wr(32'h08, 32'h0);
    chk("R3 oe with data low", 64'(pad_oe[3:0]), 64'b0110);

    // R4 pull disable
    wr(32'h10, 32'h0F);
    chk("R4 pull enables", 64'(pad_pull_en[7:0]), 64'hF0);

    // R2 last window, hole offset and out-of-range address
    wr(32'h128, 32'hA5);
    chk("R2 port 6 output data", 64'(pad_out[55:48]), 64'hA5);
    rd(32'h24, v); chk("R2 unmapped offset", 64'(v), 64'h0);
    rd(32'h150, v); chk("R2 past last window", 64'(v), 64'h0);

    // R5 / R12 pin state register
    pad_in[7:0] = 8'h5A;
    idle(4);
    rd(32'h04, v); chk("R5 pin state two-stage", 64'(v), 64'h5A);
    wr(32'h04, 32'hFF);
    rd(32'h04, v); chk("R12 pin state write ignored", 64'(v), 64'h5A);
    pad_in[7:0] = 8'h33;
    idle(1);
    rd(32'h04, v); chk("R5 two-stage still old", 64'(v), 64'h5A);
    wr(32'h00, 32'h1);
    pad_in[7:0] = 8'hCC;
    idle(1);
    rd(32'h04, v); chk("R5 one-stage already new", 64'(v), 64'hCC);
    wr(32'h00, 32'h3);
    idle(4);
    wr(32'h14, 32'hFF);

    // R6 / R8 edge select and interrupt on port 1
    wr(32'h50, 32'h04);
    wr(32'h48, 32'h04);
    pad_in[10] = 1'b1;
    pad_in[11] = 1'b1;
    idle(5);
    rd(32'h44, v); chk("R6 rising pin only", 64'(v), 64'h04);
    chk("R8 irq with enabled event", 64'(irq[1]), 64'h1);
    pad_in[11] = 1'b0;
    idle(5);
    rd(32'h44, v); chk("R6 falling pin", 64'(v), 64'h0C);
    wr(32'h44, 32'h04);
    rd(32'h44, v); chk("R7 write-one clears", 64'(v), 64'h08);
    chk("R8 irq low with only disabled event", 64'(irq[1]), 64'h0);

    // R9 / R7 force on port 2
    wr(32'h7C, 32'h81);
    idle(2);
    rd(32'h74, v); chk("R9 force sets events", 64'(v), 64'h81);
    wr(32'h74, 32'hFF);
    rd(32'h74, v); chk("R7 set wins over clear", 64'(v), 64'h81);
    wr(32'h7C, 32'h0);
    wr(32'h74, 32'hFF);
    rd(32'h74, v); chk("R9 force off then clear", 64'(v), 64'h0);

    // R10 block off
    wr(32'h48, 32'h0C);
    chk("R8 irq with pin3 enabled", 64'(irq[1]), 64'h1);
    wr(32'h00, 32'h2);
    chk("R10 irq low when off", 64'(irq), 64'h0);
    wr(32'h1C, 32'h01);
    pad_in[10] = 1'b0;
    idle(4);
    pad_in[10] = 1'b1;
    idle(4);
    rd(32'h14, v); chk("R10 no forced event when off", 64'(v), 64'h0);
    rd(32'h44, v); chk("R10 no edge event when off", 64'(v), 64'h08);
    rd(32'h1C, v); chk("R10 registers readable when off", 64'(v), 64'h01);
    wr(32'h00, 32'h3);
    idle(2);
    rd(32'h14, v); chk("R10 force acts after re-enable", 64'(v), 64'h01);
    wr(32'h1C, 32'h0);
    wr(32'h48, 32'h0);

    // random traffic checked against the model each cycle
    for (int i = 0; i < 3000; i++) begin
      pad_in    = NPIN'({$urandom, $urandom});
      bus_sel   = ($urandom % 2) == 0;
      bus_wr    = ($urandom % 3) == 0;
      bus_addr  = 9'($urandom % 352);
      if (($urandom % 4) != 0) bus_addr[1:0] = 2'b00;
      bus_wdata = $urandom;
      if (bus_wr && (int'(bus_addr) % 48) == 0 && ($urandom % 4) != 0) bus_wdata[0] = 1'b1;
      @(negedge clk);
    end
    bus_sel = 1'b0;
    bus_wr  = 1'b0;
    idle(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule